// File: doc/BRIEF.md
# Transfer Adapter Control and Status Register Block

This block holds the software-visible control side of a disk-style transfer adapter: a control register, a sticky status register, the starting virtual address and the byte count of the next transfer, and the interrupt request line. A host issues register accesses on a simple one-cycle request port and gets a registered response one cycle later. Accesses that fall into the drive window are passed through to the attached drives on a strobe interface. The block watches the command written to a drive to see when a data transfer begins.

Status is driven by a transfer engine and an address map. Both send single-cycle event pulses. Any error in the abort class ends a transfer on its own: it marks the transfer as finished and aborted, and it drops the busy flag. While a transfer is running, writes that would disturb it are refused. Instead of taking effect, each refused write raises a programming-error flag, so software learns the write had no effect.

Top module: `dma_adapter_csr`

## Requirements
- R1: Only an access with `acc_long`=1 and `acc_addr[1:0]`=0 is accepted. Any other access returns `rsp_err`=1, changes no register and strobes no drive.
- R2: Address bits 11:10 pick the region: 0 internal, 1 drive, 2 map. In the internal region, bits 9:2 index 1 control, 2 status, 3 address, 4 count. In the drive region, bits 9:7 give the drive and bits 6:2 give the drive register. Map entries and unused internal indices read as zero without an error.
- R3: An abort-class event (`ev_abort`, status bits 11:0) sets that bit plus bits 13 (finished) and 12 (aborted), and clears busy (bit 31). An `ev_done` pulse sets bit 13 and clears busy.
- R4: When interrupt-enable (control bit 2) is 1, any event that sets a status bit within mask 0x000F7000 raises `irq` on the next cycle. When enable is 0, `irq` stays low.
- R5: A control write with bit 2 at 0 drops a pending `irq`.
- R6: A status write clears every bit written as 1 that lies in mask 0x608F7FFF. Busy cannot be cleared this way. Status reads are masked with 0xE08F7FFF.
- R7: The address register (17 bits) and the count register (16 bits) load from a write only while idle. A write while busy leaves the register as it was and sets programming-error (bit 19).
- R8: A write to drive register 0 whose data has bit 0 (go) set and a low 6-bit code of 0x28 or above starts a transfer: busy is set and every bit of mask 0x608F7FFF is cleared. A lower code is still forwarded to the drive but starts nothing.
- R9: A start command that arrives while busy sets programming-error and is not forwarded to the drive.
- R10: A control write with bit 1 while busy sets the aborted bit (12) and clears busy, without setting bit 13. The same write while idle changes no status.
- R11: A control write with maintenance bit 3 while busy sets programming-error and stores bit 3 as 0. While idle, bit 3 is stored.
- R12: A control write with bit 0 set clears status, address and count. Control then holds bits 3:1 of the written value.
- R13: A count read returns the count in both halves. A drive read returns `drv_rdata` in bits 15:0 and status bits 31:16 above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_long | input | 1 | 1 = full 32-bit access |
| acc_addr | input | ADDR_W | Byte address within the adapter window |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access refused (error confirmation) |
| rsp_rdata | output | 32 | Read data |
| drv_we | output | 1 | Drive register write strobe |
| drv_re | output | 1 | Drive register read strobe |
| drv_num | output | 3 | Selected drive |
| drv_reg | output | 5 | Selected drive register |
| drv_wdata | output | 16 | Data forwarded to the drive |
| drv_rdata | input | DRV_W | Drive register read data, same cycle |
| ev_abort | input | ABORT_N | Abort-class error pulses from engine and map |
| ev_done | input | 1 | Transfer finished normally |
| ev_attn | input | 1 | Drive attention pulse |
| ev_nodrive | input | 1 | Nonexistent drive pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the interplay between the busy flag and host writes. It issues a second start, address and count writes, and a maintenance write while a transfer runs. A design that checked busy in the wrong place would let these change the registers, or would forward a duplicate go command to the drive. The bench also drives abort-class events, the abort control bit and the normal finish, and checks which of bits 13, 12 and 31 each one leaves behind; folding these cases together shows up as a wrong finished bit. Further cases are a status write of all ones during a transfer (busy must survive), a function code just below the start threshold, a pending interrupt withdrawn by clearing enable, and an init write that leaves control holding the newly written bits.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

   typedef enum logic [1:0] {
      RGN_INT  = 2'd0,
      RGN_EXT  = 2'd1,
      RGN_MAP  = 2'd2,
      RGN_NONE = 2'd3
   } region_e;

   localparam logic [7:0] IDX_CTRL = 8'd1;
   localparam logic [7:0] IDX_STAT = 8'd2;
   localparam logic [7:0] IDX_VA   = 8'd3;
   localparam logic [7:0] IDX_BC   = 8'd4;

   localparam logic [31:0] ST_READ_MASK = 32'hE08F_7FFF;
   localparam logic [31:0] ST_W1C_MASK  = 32'h608F_7FFF;
   localparam logic [31:0] ST_INT_MASK  = 32'h000F_7000;

   localparam int ST_BUSY  = 31;
   localparam int ST_PGE   = 19;
   localparam int ST_NODRV = 18;
   localparam int ST_ATTN  = 16;
   localparam int ST_DONE  = 13;
   localparam int ST_ABT   = 12;
   localparam int ST_ABORT_GROUP = 12;

   typedef struct packed {
      logic       bad;
      logic       rd;
      logic       wr;
      logic       ctrl;
      logic       stat;
      logic       va;
      logic       bc;
      logic       ext;
      logic [2:0] drv;
      logic [4:0] reg_ofs;
      logic       start;
   } acc_dec_t;

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int FUNC_MIN = 6'h28
) (
   input  logic              valid,
   input  logic              write,
   input  logic              is_long,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output acc_dec_t          dec
);
   localparam int RGN_LSB = 10;

   if (ADDR_W < 12) begin : g_addr_chk
      $error("dma_csr_decode: ADDR_W must be at least 12");
   end
   if (FUNC_MIN > 63) begin : g_func_chk
      $error("dma_csr_decode: FUNC_MIN must fit in 6 bits");
   end

   region_e    rgn;
   logic [7:0] idx;
   logic       ok;

   always_comb begin
      rgn = region_e'(addr[RGN_LSB+1:RGN_LSB]);
      idx = addr[9:2];
      ok  = valid && is_long && (addr[1:0] == 2'b00);

      dec         = '0;
      dec.bad     = valid && !ok;
      dec.rd      = ok && !write;
      dec.wr      = ok && write;
      dec.ctrl    = ok && (rgn == RGN_INT) && (idx == IDX_CTRL);
      dec.stat    = ok && (rgn == RGN_INT) && (idx == IDX_STAT);
      dec.va      = ok && (rgn == RGN_INT) && (idx == IDX_VA);
      dec.bc      = ok && (rgn == RGN_INT) && (idx == IDX_BC);
      dec.ext     = ok && (rgn == RGN_EXT);
      dec.drv     = addr[9:7];
      dec.reg_ofs = addr[6:2];
      dec.start   = dec.ext && write && (addr[6:2] == 5'd0) && wdata[0]
                    && ({26'd0, wdata[5:0]} >= 32'(FUNC_MIN));
   end

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
   import dma_csr_pkg::*;
#(
   parameter int ABORT_N = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init,
   input  logic               w1c_we,
   input  logic [31:0]        w1c_data,
   input  logic               start,
   input  logic [ABORT_N-1:0] ev_abort,
   input  logic               ev_done,
   input  logic               ev_attn,
   input  logic               ev_nodrv,
   input  logic               abort_req,
   input  logic               pge_req,
   output logic [31:0]        status_q,
   output logic               int_new
);
   if (ABORT_N < 1 || ABORT_N > ST_ABORT_GROUP) begin : g_abort_chk
      $error("dma_csr_status: ABORT_N must be 1 to 12");
   end

   logic [31:0] set_v;
   logic [31:0] nxt;

   always_comb begin
      set_v = '0;
      set_v[ABORT_N-1:0] = ev_abort;
      set_v[ST_DONE]  = ev_done;
      set_v[ST_ABT]   = abort_req;
      set_v[ST_ATTN]  = ev_attn;
      set_v[ST_NODRV] = ev_nodrv;
      set_v[ST_PGE]   = pge_req;
      if (|set_v[ST_ABORT_GROUP-1:0]) begin
         set_v[ST_DONE] = 1'b1;
         set_v[ST_ABT]  = 1'b1;
      end

      nxt = init ? '0 : status_q;
      if (w1c_we) nxt = nxt & ~(w1c_data & ST_W1C_MASK);
      if (start) begin
         nxt = nxt & ~ST_W1C_MASK;
         nxt[ST_BUSY] = 1'b1;
      end
      nxt = nxt | set_v;
      if (set_v[ST_DONE] || set_v[ST_ABT]) nxt[ST_BUSY] = 1'b0;
      nxt = nxt & ST_READ_MASK;

      int_new = |(set_v & ST_INT_MASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= nxt;
   end

endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [3:0] wdata,
   input  logic       busy,
   input  logic       int_new,
   output logic [3:1] ctrl_q,
   output logic       init,
   output logic       abort_req,
   output logic       pge_req,
   output logic       irq
);
   localparam int B_ABT = 1;
   localparam int B_IE  = 2;
   localparam int B_MNT = 3;

   logic busy_eff;
   logic irq_nxt;

   always_comb begin
      init      = wr && wdata[0];
      busy_eff  = busy && !init;
      abort_req = wr && wdata[B_ABT] && busy_eff;
      pge_req   = wr && wdata[B_MNT] && busy_eff;
      if (wr && !wdata[B_IE]) irq_nxt = 1'b0;
      else                    irq_nxt = irq || (int_new && ctrl_q[B_IE]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= irq_nxt;
         if (wr) ctrl_q <= {wdata[B_MNT] && !busy_eff, wdata[B_IE], wdata[B_ABT]};
      end
   end

endmodule

// File: rtl/dma_adapter_csr.sv
module dma_adapter_csr
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int VA_W    = 17,
   parameter int BC_W    = 16,
   parameter int ABORT_N = 12,
   parameter int DRV_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic               acc_long,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [31:0]        acc_wdata,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [31:0]        rsp_rdata,
   output logic               drv_we,
   output logic               drv_re,
   output logic [2:0]         drv_num,
   output logic [4:0]         drv_reg,
   output logic [15:0]        drv_wdata,
   input  logic [DRV_W-1:0]   drv_rdata,
   input  logic [ABORT_N-1:0] ev_abort,
   input  logic               ev_done,
   input  logic               ev_attn,
   input  logic               ev_nodrive,
   output logic               irq
);
   localparam int HALF = 16;

   if (VA_W < 1 || VA_W > 32) begin : g_va_chk
      $error("dma_adapter_csr: VA_W must be 1 to 32");
   end
   if (BC_W < 1 || BC_W > HALF) begin : g_bc_chk
      $error("dma_adapter_csr: BC_W must be 1 to 16");
   end
   if (DRV_W < 1 || DRV_W > HALF) begin : g_drv_chk
      $error("dma_adapter_csr: DRV_W must be 1 to 16");
   end

   acc_dec_t        dec;
   logic [31:0]     status_q;
   logic            int_new;
   logic [3:1]      ctrl_q;
   logic            init;
   logic            abort_req;
   logic            pge_ctrl;
   logic            busy;
   logic            pge_req;
   logic            start_ok;
   logic [VA_W-1:0] va_q;
   logic [BC_W-1:0] bc_q;
   logic [31:0]     rd_mux;

   dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .valid   (acc_valid),
      .write   (acc_write),
      .is_long (acc_long),
      .addr    (acc_addr),
      .wdata   (acc_wdata[15:0]),
      .dec     (dec)
   );

   assign busy     = status_q[ST_BUSY];
   assign start_ok = dec.start && !busy;
   assign pge_req  = pge_ctrl
                     || (dec.wr && (dec.va || dec.bc) && busy)
                     || (dec.start && busy);

   dma_csr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (dec.wr && dec.ctrl),
      .wdata     (acc_wdata[3:0]),
      .busy      (busy),
      .int_new   (int_new),
      .ctrl_q    (ctrl_q),
      .init      (init),
      .abort_req (abort_req),
      .pge_req   (pge_ctrl),
      .irq       (irq)
   );

   dma_csr_status #(.ABORT_N(ABORT_N)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (init),
      .w1c_we    (dec.wr && dec.stat),
      .w1c_data  (acc_wdata),
      .start     (start_ok),
      .ev_abort  (ev_abort),
      .ev_done   (ev_done),
      .ev_attn   (ev_attn),
      .ev_nodrv  (ev_nodrive),
      .abort_req (abort_req),
      .pge_req   (pge_req),
      .status_q  (status_q),
      .int_new   (int_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q <= '0;
         bc_q <= '0;
      end else if (init) begin
         va_q <= '0;
         bc_q <= '0;
      end else begin
         if (dec.wr && dec.va && !busy) va_q <= acc_wdata[VA_W-1:0];
         if (dec.wr && dec.bc && !busy) bc_q <= acc_wdata[BC_W-1:0];
      end
   end

   assign drv_we    = dec.wr && dec.ext && !(dec.start && busy);
   assign drv_re    = dec.rd && dec.ext;
   assign drv_num   = dec.drv;
   assign drv_reg   = dec.reg_ofs;
   assign drv_wdata = acc_wdata[15:0];

   always_comb begin
      rd_mux = '0;
      if (dec.ctrl)      rd_mux = {28'd0, ctrl_q, 1'b0};
      else if (dec.stat) rd_mux = status_q & ST_READ_MASK;
      else if (dec.va)   rd_mux = 32'(va_q);
      else if (dec.bc)   rd_mux = {HALF'(bc_q), HALF'(bc_q)};
      else if (dec.ext)  rd_mux = {status_q[31:HALF] & ST_READ_MASK[31:HALF], HALF'(drv_rdata)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_err   <= dec.bad;
         rsp_rdata <= dec.rd ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/dma_adapter_csr_chk.sv
module dma_adapter_csr_chk #(
   parameter int ADDR_W  = 12,
   parameter int VA_W    = 17,
   parameter int ABORT_N = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic               acc_write,
   input logic               acc_long,
   input logic [ADDR_W-1:0]  acc_addr,
   input logic [31:0]        acc_wdata,
   input logic               rsp_valid,
   input logic               rsp_err,
   input logic [ABORT_N-1:0] ev_abort,
   input logic [31:0]        status_q,
   input logic [VA_W-1:0]    va_q,
   input logic [3:1]         ctrl_q,
   input logic               irq
);
   logic good;
   assign good = acc_valid && acc_long && (acc_addr[1:0] == 2'b00);

   // R1: a refused access is answered with an error
   assert_bad_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !good) |=> (rsp_valid && rsp_err));

   // R3: an abort-class event leaves finished and aborted set and busy clear
   assert_abort_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_abort) |=> (!status_q[31] && status_q[13] && status_q[12]));

   // R4: the request only rises while enable was set
   assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctrl_q[2]));

   // R5: writing enable as zero withdraws the request
   assert_irq_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (good && acc_write && acc_addr[11:2] == 10'd1 && !acc_wdata[2]) |=> !irq);

   // R7: address write during a transfer is refused and flagged
   assert_va_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (good && acc_write && acc_addr[11:2] == 10'd3 && status_q[31])
      |=> ($stable(va_q) && status_q[19]));

endmodule

bind dma_adapter_csr dma_adapter_csr_chk #(
   .ADDR_W (ADDR_W),
   .VA_W   (VA_W),
   .ABORT_N(ABORT_N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_long  (acc_long),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .ev_abort  (ev_abort),
   .status_q  (status_q),
   .va_q      (va_q),
   .ctrl_q    (ctrl_q),
   .irq       (irq)
);

// File: tb/dma_adapter_csr_test.sv
module dma_adapter_csr_test;
   localparam int ADDR_W = 12;
   localparam logic [11:0] A_CTRL = 12'h004;
   localparam logic [11:0] A_STAT = 12'h008;
   localparam logic [11:0] A_VA   = 12'h00C;
   localparam logic [11:0] A_BC   = 12'h010;
   localparam logic [11:0] A_D2R0 = 12'h500;
   localparam logic [11:0] A_D3R1 = 12'h584;
   localparam logic [11:0] A_MAP  = 12'h800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0, acc_long = 1'b1;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic drv_we, drv_re;
   logic [2:0] drv_num;
   logic [4:0] drv_reg;
   logic [15:0] drv_wdata;
   logic [15:0] drv_rdata = 16'hA5C3;
   logic [11:0] ev_abort = '0;
   logic ev_done = 1'b0, ev_attn = 1'b0, ev_nodrive = 1'b0;
   logic irq;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [31:0] r_data;
   logic r_err, r_we, r_re;
   logic [2:0] r_num;
   logic [4:0] r_reg;

   always #10 clk = ~clk;

   dma_adapter_csr uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_long(acc_long),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .drv_we(drv_we), .drv_re(drv_re), .drv_num(drv_num), .drv_reg(drv_reg),
      .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
      .ev_abort(ev_abort), .ev_done(ev_done), .ev_attn(ev_attn),
      .ev_nodrive(ev_nodrive), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic lng, input logic [11:0] a,
                         input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_long = lng; acc_addr = a; acc_wdata = d;
      #1;
      r_we = drv_we; r_re = drv_re; r_num = drv_num; r_reg = drv_reg;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_long = 1'b1;
      r_data = rsp_rdata; r_err = rsp_err;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      access(1'b1, 1'b1, a, d);
   endtask

   task automatic rd(input logic [11:0] a);
      access(1'b0, 1'b1, a, 32'd0);
   endtask

   task automatic pulse(input logic [11:0] ab, input logic dn, input logic at, input logic nd);
      @(negedge clk);
      ev_abort = ab; ev_done = dn; ev_attn = at; ev_nodrive = nd;
      @(negedge clk);
      ev_abort = '0; ev_done = 1'b0; ev_attn = 1'b0; ev_nodrive = 1'b0;
   endtask

   task automatic t_reset;
      rd(A_STAT); check("R12 reset status", r_data, 32'h0);
      rd(A_CTRL); check("R12 reset control", r_data, 32'h0);
      check("R4 reset irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_bad;
      rd(12'h00A); check("R1 unaligned read err", {31'd0, r_err}, 32'h1);
      access(1'b1, 1'b0, A_BC, 32'h55);
      check("R1 narrow write err", {31'd0, r_err}, 32'h1);
      rd(A_BC); check("R1 narrow write ignored", r_data, 32'h0);
   endtask

   task automatic t_regs;
      wr(A_VA, 32'hFFFF_FFFF);
      rd(A_VA); check("R7 address width", r_data, 32'h0001_FFFF);
      wr(A_BC, 32'h1234_ABCD);
      rd(A_BC); check("R13 count both halves", r_data, 32'hABCD_ABCD);
      rd(A_MAP); check("R2 map reads zero", r_data, 32'h0);
      check("R2 map no err", {31'd0, r_err}, 32'h0);
      rd(12'h01C); check("R2 unused index zero", r_data, 32'h0);
   endtask

   task automatic t_start;
      pulse(12'h002, 1'b0, 1'b0, 1'b0);
      rd(A_STAT); check("R3 idle abort event", r_data, 32'h0000_3002);
      wr(A_D2R0, 32'h21);
      check("R8 low code forwarded", {29'd0, r_we, r_num[1:0]}, {29'd0, 1'b1, 2'd2});
      rd(A_STAT); check("R8 low code no start", r_data, 32'h0000_3002);
      wr(A_D2R0, 32'h39);
      check("R8 start forwarded", {31'd0, r_we}, 32'h1);
      rd(A_STAT); check("R8 start sets busy", r_data, 32'h8000_0000);
   endtask

   task automatic t_busy_reject;
      wr(A_D2R0, 32'h39);
      check("R9 second start not forwarded", {31'd0, r_we}, 32'h0);
      rd(A_STAT); check("R9 second start flags", r_data, 32'h8008_0000);
      wr(A_VA, 32'h5);
      rd(A_VA); check("R7 busy address held", r_data, 32'h0001_FFFF);
      wr(A_BC, 32'h0);
      rd(A_BC); check("R7 busy count held", r_data, 32'hABCD_ABCD);
   endtask

   task automatic t_ext_read;
      rd(A_D3R1);
      check("R2 drive decode", {24'd0, r_re, r_num, r_reg[3:0]}, {24'd0, 1'b1, 3'd3, 4'd1});
      check("R13 drive read", r_data, 32'h8008_A5C3);
   endtask

   task automatic t_mnt;
      wr(A_STAT, 32'h0008_0000);
      rd(A_STAT); check("R6 clear flag", r_data, 32'h8000_0000);
      wr(A_CTRL, 32'h8);
      rd(A_CTRL); check("R11 busy maint not stored", r_data, 32'h0);
      rd(A_STAT); check("R11 busy maint flags", r_data, 32'h8008_0000);
   endtask

   task automatic t_abort;
      wr(A_CTRL, 32'h2);
      rd(A_STAT); check("R10 abort status", r_data, 32'h0008_1000);
      wr(A_CTRL, 32'h2);
      rd(A_STAT); check("R10 idle abort no effect", r_data, 32'h0008_1000);
   endtask

   task automatic t_w1c;
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT); check("R6 clear all", r_data, 32'h0);
      wr(A_D2R0, 32'h39);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT); check("R6 busy read-only", r_data, 32'h8000_0000);
   endtask

   task automatic t_done;
      pulse(12'h0, 1'b1, 1'b0, 1'b0);
      rd(A_STAT); check("R3 done ends busy", r_data, 32'h0000_2000);
      wr(A_D2R0, 32'h39);
      pulse(12'h010, 1'b0, 1'b0, 1'b0);
      rd(A_STAT); check("R3 abort-class ends busy", r_data, 32'h0000_3010);
   endtask

   task automatic t_irq;
      wr(A_CTRL, 32'h4);
      check("R4 no irq yet", {31'd0, irq}, 32'h0);
      pulse(12'h0, 1'b0, 1'b1, 1'b0);
      check("R4 attention raises irq", {31'd0, irq}, 32'h1);
      wr(A_CTRL, 32'h0);
      check("R5 enable cleared drops irq", {31'd0, irq}, 32'h0);
      pulse(12'h0, 1'b1, 1'b0, 1'b0);
      check("R4 disabled no irq", {31'd0, irq}, 32'h0);
      wr(A_CTRL, 32'h4);
      pulse(12'h0, 1'b0, 1'b0, 1'b1);
      check("R4 no-drive raises irq", {31'd0, irq}, 32'h1);
      wr(A_CTRL, 32'h0);
   endtask

   task automatic t_init;
      wr(A_CTRL, 32'h8);
      rd(A_CTRL); check("R11 idle maint stored", r_data, 32'h8);
      wr(A_VA, 32'h123);
      wr(A_CTRL, 32'h9);
      rd(A_CTRL); check("R12 init control", r_data, 32'h8);
      rd(A_STAT); check("R12 init status", r_data, 32'h0);
      rd(A_VA);   check("R12 init address", r_data, 32'h0);
      rd(A_BC);   check("R12 init count", r_data, 32'h0);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL); check("R12 init takes written bits", r_data, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_bad;
      t_regs;
      t_start;
      t_busy_reject;
      t_ext_read;
      t_mnt;
      t_abort;
      t_w1c;
      t_done;
      t_irq;
      t_init;
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule